// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block is the read-side output path of a synchronous burst SRAM. Each clock edge it captures a command: deselect, read or write. For a captured read, the array supplies data during the next cycle. The block presents that data on a data bus with a drive-enable, in one of two timing modes chosen by a static strap. In flow-through mode the array word passes straight to the bus in the cycle after the read is captured. A read then gives first data at the second clock, and a burst runs 2-1-1-1. In pipelined mode the word is first loaded into an output register on the following rising edge. First data then comes at the third clock, and a burst runs 3-1-1-1.

A deselect does not pass through the array stage, so it takes one fewer stage than read data to reach the bus. In pipelined mode this lets the last beat of a burst stay on the bus for exactly one cycle before the drivers turn off. A captured write turns the drivers off at once. An output-enable input gates the drivers without waiting for a clock. The strap has a companion input that tells the block whether the strap is actually tied. A floating strap selects pipelined timing.

Top module: `sram_rdout`

## Requirements
- R1: Flow-through mode (`pipe_sel_tied`=1, `pipe_sel`=0). A read captured at edge k drives `dq_drive`=1 and `dq_data`=`arr_rdata` during the cycle between edges k and k+1, provided `out_en_async`=1.
- R2: Pipelined mode (`pipe_sel_tied`=1, `pipe_sel`=1). A read captured at edge k loads the `arr_rdata` word presented between edges k and k+1. That word is driven on `dq_data`, with `dq_drive`=1, during the cycle after edge k+1.
- R3: Reads captured on consecutive edges produce a new driven beat every cycle in both modes, with no gap between beats.
- R4: When `pipe_sel_tied`=0 the strap counts as floating, and the block uses pipelined timing whatever the value of `pipe_sel`.
- R5: A deselect (`cmd` 2'b00 or 2'b11) captured at edge k turns the drivers off one stage sooner than read data travels. In flow-through mode the drivers are off from edge k. In pipelined mode they are off from edge k+1, after the previous read's beat has had its one cycle on the bus.
- R6: A write (`cmd` 2'b10) captured at edge k holds `dq_drive` low until edge k+1 in both modes. This holds even when a pipelined read beat is waiting in the output register.
- R7: While `out_en_async`=0, `dq_drive` is 0. When it returns to 1, driving resumes without a clock edge.
- R8: While `rst_n` is low and after its release, `dq_drive` stays 0 until a read has been captured. The pipelined output register clears during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_sel | input | 1 | Timing strap: 1 pipelined, 0 flow-through |
| pipe_sel_tied | input | 1 | 1 when the strap is driven; 0 means floating, which selects pipelined |
| cmd | input | 2 | Command captured each edge: 00 deselect, 01 read, 10 write, 11 deselect |
| arr_rdata | input | DATA_W | Array word for the read captured at the previous edge |
| out_en_async | input | 1 | Asynchronous output enable, active high |
| dq_data | output | DATA_W | Read data; all X while not driven |
| dq_drive | output | 1 | Output driver enable |

## Verification
The properties assume that the strap pair changes only after at least two deselects have been captured, so that no beat is in flight across a mode change. The stimulus keeps to this by issuing two deselect cycles before every mode switch and by applying the new strap values only at that point. The properties also assume that `arr_rdata` and `cmd` are stable around the rising edge. The bench meets this by driving every input on the falling edge and by toggling the output enable only in the first part of a cycle.

// File: rtl/sram_rdout_pkg.sv
`timescale 1ns/1ps
package sram_rdout_pkg;

   // Command code captured on each rising edge
   typedef enum logic [1:0] {
      CMD_DESEL     = 2'b00,
      CMD_READ      = 2'b01,
      CMD_WRITE     = 2'b10,
      CMD_DESEL_ALT = 2'b11
   } rd_cmd_e;

   localparam int CMD_W = $bits(rd_cmd_e);

endpackage

// File: rtl/sram_rdout_cmd_stage.sv
`timescale 1ns/1ps
// Input register: turns the captured command into read / write flags.
module sram_rdout_cmd_stage
   import sram_rdout_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] cmd_i,
   output logic             rd_cap_o,
   output logic             wr_cap_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_cap_o <= 1'b0;
         wr_cap_o <= 1'b0;
      end else begin
         rd_cap_o <= (cmd_i == CMD_READ);
         wr_cap_o <= (cmd_i == CMD_WRITE);
      end
   end

endmodule

// File: rtl/sram_rdout_data_stage.sv
`timescale 1ns/1ps
// Output register for pipelined timing, with its read-pending flag.
module sram_rdout_data_stage #(
   parameter int DATA_W     = 36,
   parameter bit DATA_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_cap_i,
   input  logic [DATA_W-1:0] arr_rdata_i,
   output logic              rd_late_o,
   output logic [DATA_W-1:0] data_q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) rd_late_o <= 1'b0;
      else        rd_late_o <= rd_cap_i;
   end

   generate
      if (DATA_RESET) begin : g_rst_data
         always_ff @(posedge clk) begin
            if (!rst_n)        data_q_o <= '0;
            else if (rd_cap_i) data_q_o <= arr_rdata_i;
         end
      end else begin : g_free_data
         always_ff @(posedge clk) begin
            if (rd_cap_i) data_q_o <= arr_rdata_i;
         end
      end
   endgenerate

endmodule

// File: rtl/sram_rdout_drive.sv
`timescale 1ns/1ps
// Mode mux, deselect / write turn-off and asynchronous enable gating.
module sram_rdout_drive #(
   parameter int DATA_W = 36
) (
   input  logic              pipe_mode_i,
   input  logic              out_en_i,
   input  logic              rd_cap_i,
   input  logic              wr_cap_i,
   input  logic              rd_late_i,
   input  logic [DATA_W-1:0] arr_rdata_i,
   input  logic [DATA_W-1:0] data_q_i,
   output logic [DATA_W-1:0] dq_data_o,
   output logic              dq_drive_o
);

   logic              sync_on;
   logic [DATA_W-1:0] sel_data;

   always_comb begin
      if (pipe_mode_i) begin
         // deselect clears rd_late one stage after capture; a write blocks at once
         sync_on  = rd_late_i & ~wr_cap_i;
         sel_data = data_q_i;
      end else begin
         sync_on  = rd_cap_i;
         sel_data = arr_rdata_i;
      end
   end

   assign dq_drive_o = sync_on & out_en_i;
   assign dq_data_o  = dq_drive_o ? sel_data : {DATA_W{1'bx}};

endmodule

// File: rtl/sram_rdout.sv
`timescale 1ns/1ps
module sram_rdout
   import sram_rdout_pkg::*;
#(
   parameter int DATA_W     = 36,
   parameter bit DATA_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_sel,
   input  logic              pipe_sel_tied,
   input  logic [1:0]        cmd,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic              out_en_async,
   output logic [DATA_W-1:0] dq_data,
   output logic              dq_drive
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("sram_rdout: DATA_W must be at least 1");
      end
      if (CMD_W != 2) begin : g_bad_cmd
         $error("sram_rdout: command code must be two bits");
      end
   endgenerate

   logic pipe_mode;
   logic rd_cap, wr_cap, rd_late;
   logic [DATA_W-1:0] data_q;

   // floating strap falls back to pipelined timing
   assign pipe_mode = ~pipe_sel_tied | pipe_sel;

   sram_rdout_cmd_stage u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_i    (cmd),
      .rd_cap_o (rd_cap),
      .wr_cap_o (wr_cap)
   );

   sram_rdout_data_stage #(
      .DATA_W     (DATA_W),
      .DATA_RESET (DATA_RESET)
   ) u_data (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_cap_i    (rd_cap),
      .arr_rdata_i (arr_rdata),
      .rd_late_o   (rd_late),
      .data_q_o    (data_q)
   );

   sram_rdout_drive #(
      .DATA_W (DATA_W)
   ) u_drive (
      .pipe_mode_i (pipe_mode),
      .out_en_i    (out_en_async),
      .rd_cap_i    (rd_cap),
      .wr_cap_i    (wr_cap),
      .rd_late_i   (rd_late),
      .arr_rdata_i (arr_rdata),
      .data_q_i    (data_q),
      .dq_data_o   (dq_data),
      .dq_drive_o  (dq_drive)
   );

endmodule

// File: rtl/sram_rdout_chk.sv
`timescale 1ns/1ps
module sram_rdout_chk
   import sram_rdout_pkg::*;
#(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pipe_sel,
   input logic              pipe_sel_tied,
   input logic [1:0]        cmd,
   input logic [DATA_W-1:0] arr_rdata,
   input logic              out_en_async,
   input logic [DATA_W-1:0] dq_data,
   input logic              dq_drive
);

   logic [1:0] age;
   logic       pe;

   always_ff @(posedge clk) begin
      if (!rst_n)           age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   assign pe = ~pipe_sel_tied | pipe_sel;

   // R1: flow-through beat is the live array word
   p_ft_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && !pe && $past(cmd) == CMD_READ && out_en_async)
      |-> (dq_drive && dq_data == arr_rdata));

   // R2 / R4: pipelined beat is last cycle's array word
   p_pipe_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2 && pe && $past(cmd, 2) == CMD_READ &&
       $past(cmd) != CMD_WRITE && out_en_async)
      |-> (dq_drive && dq_data == $past(arr_rdata)));

   // R5: no drive once the deselect has passed its shorter path
   p_desel_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2 && ((pe && $past(cmd, 2) != CMD_READ) ||
                       (!pe && $past(cmd) != CMD_READ)))
      |-> !dq_drive);

   // R6: captured write silences the bus
   p_write_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && $past(cmd) == CMD_WRITE) |-> !dq_drive);

   // R7: enable gating
   p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en_async |-> !dq_drive);

endmodule

bind sram_rdout sram_rdout_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pipe_sel     (pipe_sel),
   .pipe_sel_tied(pipe_sel_tied),
   .cmd          (cmd),
   .arr_rdata    (arr_rdata),
   .out_en_async (out_en_async),
   .dq_data      (dq_data),
   .dq_drive     (dq_drive)
);

// File: tb/sram_rdout_bench.sv
`timescale 1ns/1ps
module sram_rdout_bench;
   import sram_rdout_pkg::*;

   localparam int W = 36;

   typedef struct {
      logic         drive;
      logic [W-1:0] data;
      string        req;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pipe_sel = 1'b0;
   logic         pipe_sel_tied = 1'b1;
   logic [1:0]   cmd = CMD_DESEL;
   logic [W-1:0] arr_rdata = '0;
   logic         out_en_async = 1'b1;
   logic [W-1:0] dq_data;
   logic         dq_drive;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   exp_t sb[$];

   logic [1:0]   h1 = CMD_DESEL, h2 = CMD_DESEL, h3 = CMD_DESEL;
   logic [W-1:0] prev_arr = '0;
   logic         m_tied = 1'b1, m_sel = 1'b0;

   always #2.5 clk = ~clk;  // 200 MHz

   sram_rdout #(.DATA_W(W)) u_sram_rdout (
      .clk          (clk),
      .rst_n        (rst_n),
      .pipe_sel     (pipe_sel),
      .pipe_sel_tied(pipe_sel_tied),
      .cmd          (cmd),
      .arr_rdata    (arr_rdata),
      .out_en_async (out_en_async),
      .dq_data      (dq_data),
      .dq_drive     (dq_drive)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at cycle %0d",
                  req, what, act, expv, cyc);
      end
   endtask

   // driver: one command per cycle, expectation pushed for this cycle
   task automatic step(input logic [1:0] c, input logic oe, input bit async_chk);
      exp_t e;
      logic pe;
      @(negedge clk);
      cyc++;
      pipe_sel_tied = m_tied;
      pipe_sel      = m_sel;
      cmd           = c;
      out_en_async  = oe;
      arr_rdata     = {cyc[17:0] ^ 18'h2a5c3, ~cyc[17:0]};
      pe = !m_tied || m_sel;
      if (pe) begin
         e.drive = oe && h2 == CMD_READ && h1 != CMD_WRITE;
         e.data  = prev_arr;
         e.req   = !m_tied ? "R4" : (h3 == CMD_READ ? "R3" : "R2");
      end else begin
         e.drive = oe && h1 == CMD_READ;
         e.data  = arr_rdata;
         e.req   = h2 == CMD_READ ? "R3" : "R1";
      end
      if (!e.drive) begin
         if (!oe)                                     e.req = "R7";
         else if (h1 == CMD_WRITE)                    e.req = "R6";
         else                                         e.req = "R5";
      end
      sb.push_back(e);
      h3 = h2; h2 = h1; h1 = c;
      prev_arr = arr_rdata;
      if (async_chk && e.drive) begin
         #0.5 out_en_async = 1'b0;
         #0.4 chk(dq_drive == 1'b0, "R7", "drive with enable low",
                  W'(dq_drive), W'(0));
         out_en_async = 1'b1;
         #0.4 chk(dq_drive == 1'b1, "R7", "drive after enable back",
                  W'(dq_drive), W'(1));
      end
   endtask

   task automatic set_mode(input logic tied, input logic sel);
      step(CMD_DESEL, 1'b1, 1'b0);
      step(CMD_DESEL, 1'b1, 1'b0);
      m_tied = tied;
      m_sel  = sel;
   endtask

   // common command pattern
   task automatic run_pattern();
      step(CMD_READ,  1'b1, 1'b0);
      step(CMD_READ,  1'b1, 1'b0);
      step(CMD_READ,  1'b1, 1'b0);
      step(CMD_READ,  1'b1, 1'b0);
      step(CMD_DESEL, 1'b1, 1'b0);
      step(CMD_DESEL_ALT, 1'b1, 1'b0);
      step(CMD_DESEL, 1'b1, 1'b0);
      step(CMD_READ,  1'b1, 1'b0);
      step(CMD_WRITE, 1'b1, 1'b0);
      step(CMD_READ,  1'b1, 1'b0);
      step(CMD_READ,  1'b1, 1'b1);
      step(CMD_READ,  1'b0, 1'b0);
      step(CMD_DESEL, 1'b1, 1'b1);
      step(CMD_DESEL, 1'b1, 1'b0);
      step(CMD_DESEL, 1'b1, 1'b0);
   endtask

   // monitor: pops one expectation per cycle, just before the edge
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            chk(dq_drive == e.drive, e.req, "dq_drive", W'(dq_drive), W'(e.drive));
            if (e.drive)
               chk(dq_data == e.data, e.req, "dq_data", dq_data, e.data);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      repeat (2) @(negedge clk);
      #1 chk(dq_drive == 1'b0, "R8", "drive in reset", W'(dq_drive), W'(0));
      m_sel = 1'b1;
      @(negedge clk);
      pipe_sel = 1'b1;
      #1 chk(dq_drive == 1'b0, "R8", "pipelined drive in reset",
             W'(dq_drive), W'(0));
      @(negedge clk);
      rst_n = 1'b1;
      step(CMD_DESEL, 1'b1, 1'b0);
      step(CMD_DESEL, 1'b1, 1'b0);
      #1 chk(dq_drive == 1'b0, "R8", "drive after reset", W'(dq_drive), W'(0));

      // flow-through: R1 R3 R5 R6 R7
      set_mode(1'b1, 1'b0);
      run_pattern();

      // pipelined: R2 R3 R5 R6 R7
      set_mode(1'b1, 1'b1);
      run_pattern();
      step(CMD_READ,  1'b1, 1'b0);
      step(CMD_WRITE, 1'b1, 1'b0);
      step(CMD_DESEL, 1'b1, 1'b0);

      // floating strap: R4
      set_mode(1'b0, 1'b0);
      run_pattern();

      repeat (3) step(CMD_DESEL, 1'b1, 1'b0);
      @(negedge clk);
      #3;
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule